// File: doc/BRIEF.md
# Serial Registration Code Checker

This block takes in a 64-bit device registration code that arrives one bit at a time. A bit is taken on each clock edge where the strobe input is high, and the code is sent least significant bit first. The code is laid out as an 8-bit family code, then a 48-bit serial number, then an 8-bit check byte. As each bit arrives, the block updates a reflected CRC-8 register over the polynomial x^8 + x^5 + x^4 + 1. Once all 64 bits are in, the block reports three things: whether the code is intact (the CRC remainder is zero), the family code, and the serial number. It also flags whether the family code equals the expected value of 09h.

A small state machine controls the block. Its states are ST_IDLE (cleared, no bit taken yet), ST_COLLECT (at least one bit taken) and ST_COMPLETE (all 64 bits taken). It has four transitions:

- T_START: ST_IDLE to ST_COLLECT, on the first accepted bit.
- T_FINISH: ST_COLLECT to ST_COMPLETE, on the 64th accepted bit.
- T_HOLD: ST_COMPLETE stays where it is.
- T_RESTART: from any state to ST_IDLE, when the synchronous clear input is high.

A host clears the block, shifts in a code, and waits for the one-cycle done pulse before it reads the results. The results stay in place until the next clear.

Top module: `romid_checker`

## Requirements
- R1: After asynchronous reset, done, code_ok and family_match are 0, and family and serial are all zeros.
- R2: done is 1 for exactly one cycle. That cycle follows the clock edge that accepts the 64th bit.
- R3: code_ok is 1 when the CRC over all 64 bits is zero. The CRC is reflected, uses feedback constant 8Ch (x^8+x^5+x^4+1), starts from 0 and is fed LSB first. code_ok stays 1 until a clear.
- R4: code_ok is never 1 before 64 bits have been accepted, even if the partial remainder is zero.
- R5: Once done, family holds code bits 7:0 (the first bit received is family bit 0). serial holds code bits 55:8, with code bit 8 as serial bit 0.
- R6: family_match is 1 only in ST_COMPLETE, and only when family equals 09h. It does not depend on the CRC result.
- R7: Clock edges where bit_valid is low change nothing, whatever the value of bit_in.
- R8: clr restarts the bit count and the CRC, and drops code_ok, done and family_match on the next cycle. clr wins over a strobe in the same cycle.
- R9: After completion, further strobes are ignored until the next clr: no done pulse, and the fields and code_ok stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart |
| bit_valid | input | 1 | Strobe: take bit_in on this edge |
| bit_in | input | 1 | Serial code bit, LSB first |
| done | output | 1 | One-cycle pulse after the 64th bit |
| code_ok | output | 1 | CRC remainder is zero after 64 bits |
| family_match | output | 1 | Family code equals 09h, after completion |
| family | output | 8 | Received family code |
| serial | output | 48 | Received serial number |

## Verification
Every result is registered once, at the edge that accepts the 64th bit. done, code_ok, family_match, family and serial therefore all show their values in the cycle that follows that edge. done falls again one cycle later.

The bench drives inputs on falling edges and samples on the falling edge right after the final strobe's rising edge. It samples once more one cycle later to see done drop while code_ok holds. For clr, the effect is checked one falling edge after the rising edge that registers the clear.

// File: rtl/romid_pkg.sv
package romid_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COLLECT  = 2'd1,
        ST_COMPLETE = 2'd2
    } rid_state_e;
endpackage

// File: rtl/romid_crc.sv
module romid_crc #(
    parameter int          CRC_W = 8,
    parameter logic [7:0]  POLY  = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc,
    output logic             zero
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic             fb;

    // reflected update: feedback = input ^ lsb, shift right, xor constant
    always_comb begin
        fb       = din ^ crc_q[0];
        crc_next = crc_q >> 1;
        if (fb) begin
            crc_next = crc_next ^ POLY[CRC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= crc_next;
        end
    end

    assign crc  = crc_q;
    assign zero = (crc_q == '0);

    // R8: a clear leaves the register empty
    p_crc_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0));
endmodule

// File: rtl/romid_bitcount.sv
module romid_bitcount #(
    parameter int N_BITS = 64,
    localparam int CNT_W = $clog2(N_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic             last,
    output logic             full
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(N_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(N_BITS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != FULL_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == LAST_V);
    assign full  = (cnt_q == FULL_V);

    // R9: the count never runs past the code length
    p_count_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clr |=> full);
endmodule

// File: rtl/romid_shreg.sv
module romid_shreg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sr_q;

    // newest bit enters at the top; after W bits the first bit is at 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clr) begin
            sr_q <= '0;
        end else if (en) begin
            sr_q <= {din, sr_q[W-1:1]};
        end
    end

    assign q = sr_q;

    // R7: no strobe, no movement
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !clr |=> $stable(q));
endmodule

// File: rtl/romid_checker.sv
module romid_checker #(
    parameter int          FAM_W      = 8,
    parameter int          SER_W      = 48,
    parameter int          CRC_W      = 8,
    parameter logic [7:0]  CRC_POLY   = 8'h8C,
    parameter logic [7:0]  EXP_FAMILY = 8'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             done,
    output logic             code_ok,
    output logic             family_match,
    output logic [FAM_W-1:0] family,
    output logic [SER_W-1:0] serial
);
    import romid_pkg::*;

    localparam int CODE_W  = FAM_W + SER_W + CRC_W;
    localparam int CNT_W   = $clog2(CODE_W + 1);
    localparam int SER_LSB = FAM_W;

    rid_state_e       state_q;
    rid_state_e       state_d;
    logic             accept;
    logic             cnt_last;
    logic             cnt_full;
    logic [CNT_W-1:0] cnt;
    logic             crc_zero;
    logic [CRC_W-1:0] crc_val;
    logic [CODE_W-1:0] code_q;
    logic             done_q;

    assign accept = bit_valid && !clr && (state_q != ST_COMPLETE);

    romid_bitcount #(.N_BITS(CODE_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(accept),
        .count(cnt), .last(cnt_last), .full(cnt_full)
    );

    romid_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(accept), .din(bit_in),
        .crc(crc_val), .zero(crc_zero)
    );

    romid_shreg #(.W(CODE_W)) u_code (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(accept), .din(bit_in),
        .q(code_q)
    );

    // next state: T_START, T_FINISH, T_HOLD, T_RESTART
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_d = cnt_last ? ST_COMPLETE : ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (accept && cnt_last) begin
                        state_d = ST_COMPLETE;
                    end
                end
                ST_COMPLETE: begin
                    state_d = ST_COMPLETE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register and decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= accept && cnt_last;
        end
    end

    always_comb begin
        done         = done_q;
        code_ok      = (state_q == ST_COMPLETE) && crc_zero;
        family       = code_q[FAM_W-1:0];
        serial       = code_q[SER_LSB +: SER_W];
        family_match = (state_q == ST_COMPLETE) &&
                       (code_q[FAM_W-1:0] == EXP_FAMILY[FAM_W-1:0]);
    end

    // R2: done never lasts two cycles
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done follows a full count
    p_done_after_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cnt_full);

    // R4: a good verdict needs all bits counted
    p_ok_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |-> cnt_full);

    // R3: verdict holds until clear
    p_ok_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok && !clr |=> code_ok);

    // R8: clear drops every result
    p_clr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !code_ok && !done && !family_match);

    // R9: fields frozen once complete
    p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMPLETE) && !clr |=> $stable(family) && $stable(serial));

    // R6: match only after completion
    p_match_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
        family_match |-> cnt_full);
endmodule

// File: tb/romid_checker_tb.sv
`timescale 1ns/1ps
module romid_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        done;
    logic        code_ok;
    logic        family_match;
    logic [7:0]  family;
    logic [47:0] serial;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    romid_checker dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(bit_valid),
        .bit_in(bit_in), .done(done), .code_ok(code_ok),
        .family_match(family_match), .family(family), .serial(serial)
    );

    localparam int NV = 6;
    localparam logic [55:0] VEC_ID [NV] = '{
        56'h000000FBD8B3_09,
        56'h000000000000_00,
        56'hA5C31E770F42_01,
        56'h123456789ABC_09,
        56'hFFFFFFFFFFFF_09,
        56'h000000FBC52B_09
    };
    localparam int VEC_FLIP [NV] = '{-1, -1, -1, 20, 61, -1};
    localparam int VEC_GAP  [NV] = '{0, 0, 1, 0, 0, 3};

    // code assembled from the rule in R3: reflected, constant 8Ch, start 0
    function automatic logic [63:0] make_code(input logic [55:0] id);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic f = id[i] ^ c[0];
            c = {1'b0, c[7:1]} ^ (f ? 8'h8C : 8'h00);
        end
        return {c, id};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_clr(input bit with_strobe);
        @(negedge clk);
        clr = 1'b1;
        bit_valid = with_strobe;
        bit_in = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        bit_valid = 1'b0;
    endtask

    // sends n bits; gap idle cycles between bits with bit_in scrambled (R7)
    task automatic send_bits(input logic [63:0] code, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    bit_valid = 1'b0;
                    bit_in = ~code[i];
                end
            end
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in = code[i];
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] code;
        repeat (3) @(negedge clk);
        check("R1 done", done, 0);
        check("R1 code_ok", code_ok, 0);
        check("R1 family_match", family_match, 0);
        check("R1 family", family, 0);
        check("R1 serial", serial, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            code = make_code(VEC_ID[v]);
            if (VEC_FLIP[v] >= 0) code[VEC_FLIP[v]] = ~code[VEC_FLIP[v]];
            pulse_clr(1'b0);
            send_bits(code, 64, VEC_GAP[v]);
            check("R2 done pulse", done, 1);
            check("R3 code_ok", code_ok, (VEC_FLIP[v] < 0) ? 1 : 0);
            check("R5 family", family, code[7:0]);
            check("R5 serial", serial, code[55:8]);
            check("R6 family_match", family_match, (code[7:0] == 8'h09) ? 1 : 0);
            if (VEC_GAP[v] > 0) check("R7 gaps ignored", code_ok, 1);
            @(negedge clk);
            check("R2 done falls", done, 0);
            check("R3 code_ok held", code_ok, (VEC_FLIP[v] < 0) ? 1 : 0);
        end

        // R4: 63 zero bits leave a zero remainder but no verdict
        pulse_clr(1'b0);
        send_bits(64'h0, 63, 0);
        check("R4 no early ok", code_ok, 0);
        check("R4 no early done", done, 0);
        send_bits(64'h0, 1, 0);
        check("R4 ok at 64", code_ok, 1);
        check("R4 done at 64", done, 1);
        check("R6 no match family 00", family_match, 0);

        // R9: strobes after completion ignored
        send_bits(64'hFFFF_FFFF_FFFF_FFFF, 8, 0);
        check("R9 no second done", done, 0);
        check("R9 family kept", family, 0);
        check("R9 ok kept", code_ok, 1);

        // R8: clear mid-stream with a strobe in the clear cycle
        code = make_code(VEC_ID[0]);
        pulse_clr(1'b0);
        send_bits(code, 30, 0);
        pulse_clr(1'b1);
        check("R8 clear drops ok", code_ok, 0);
        check("R8 family restarted", family, 0);
        code = make_code(VEC_ID[3]);
        send_bits(code, 64, 0);
        check("R8 restart done", done, 1);
        check("R8 restart ok", code_ok, 1);
        check("R8 restart family", family, 8'h09);
        check("R8 restart match", family_match, 1);
        pulse_clr(1'b0);
        check("R8 clr ok low", code_ok, 0);
        check("R8 clr match low", family_match, 0);
        check("R8 clr done low", done, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule